// File: doc/BRIEF.md
# Display Column Attribute Gater

This block decides, cycle by cycle, whether the column drivers of one digit of a multiplexed dot-matrix LED display may conduct. It combines three attribute sources. The first is a brightness code that sets the average on-time of the column drive through a duty-cycle pattern, while the peak drive stays as it is. The second is a per-digit flash mask that can be switched on as a group. The third is a global blink that acts on every digit. The scan logic presents the index of the digit that is being driven, and the block returns a single column enable for that digit.

Two counters sit inside the block. Both advance only on cycles where the display-clock enable `tick` is high. A 15-slot sub-period counter sets the brightness duty. A long prescaler produces the slow attribute square wave, whose default period is 28,672 ticks. A synchronous reset clears both counters. Several instances that share a clock, a tick and a reset therefore flash and blink in exact phase. Font lookup and row scanning are handled elsewhere.

Top module: `attr_gate`

## Requirements
- R1: A synchronous reset (`rst_n` low at a rising edge) clears the tick count. On the first cycle after reset the sub-period slot is 0 and the square wave is in its on half, so `col_en` is 1 when `bright_code` is 3'b000 and the attributes are off.
- R2: `bright_code` values 0 to 7 light the column during 15, 12, 8, 6, 4, 3, 2 and 0 slots of every 15-slot sub-period. Each slot lasts one tick.
- R3: `bright_code` = 3'b111 keeps `col_en` at 0 in every cycle.
- R4: The square wave is on for ticks 0 to PERIOD/2-1 after reset and off for ticks PERIOD/2 to PERIOD-1. It then repeats with a period of PERIOD ticks (default 28,672).
- R5: With `flash_en` = 1 and `blink_en` = 0, the selected digit is dark during the off half when bit `digit_idx` of `flash_mask` is 1. When that bit is 0, the digit follows brightness only.
- R6: With `flash_en` = 0 and `blink_en` = 0, `flash_mask` has no effect on `col_en`.
- R7: With `blink_en` = 1, every digit is dark during the off half, whatever `flash_en` and `flash_mask` hold.
- R8: Both counters hold their value in cycles where `tick` = 0.
- R9: Within each sub-period the lit slots come first. In slot s, the column is lit exactly when s < duty(bright_code).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low, clears both counters |
| tick | input | 1 | Display-clock enable, advances both counters |
| bright_code | input | 3 | Brightness code, 0 is full and 7 is blank |
| flash_en | input | 1 | Enables per-digit flashing from `flash_mask` |
| blink_en | input | 1 | Blinks all digits, takes priority over flash |
| flash_mask | input | 8 | One flash bit per digit, bit i belongs to digit i |
| digit_idx | input | 3 | Index of the digit currently driven |
| col_en | output | 1 | Column enable for the current digit |

## Verification
A slot counter that has slipped or skipped changes where the lit run sits inside the sub-period. The port shows this within one 15-tick sub-period at any code between 1 and 6. A prescaler that miscounts moves the edge of the dark half. With flash or blink active this appears at the first half-period boundary, which is PERIOD/2 ticks after reset. A bad mask lookup or a wrong priority shows up on the very cycle where the off half and the affected digit coincide. The bench compares every cycle against a counting model, so any of these faults is reported on the first cycle where it reaches `col_en`.

// File: rtl/attr_pkg.sv
package attr_pkg;
  localparam int SLOTS   = 15;
  localparam int SLOT_W  = $clog2(SLOTS);
  localparam int CODE_W  = 3;

  // Lit slots per sub-period for each brightness code.
  function automatic logic [SLOT_W-1:0] duty_of(input logic [CODE_W-1:0] code);
    logic [SLOT_W-1:0] d;
    case (code)
      3'd0:    d = 4'd15;
      3'd1:    d = 4'd12;
      3'd2:    d = 4'd8;
      3'd3:    d = 4'd6;
      3'd4:    d = 4'd4;
      3'd5:    d = 4'd3;
      3'd6:    d = 4'd2;
      default: d = 4'd0;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/attr_prescaler.sv
module attr_prescaler #(
  parameter int PERIOD = 28672,
  localparam int PH_W = $clog2(PERIOD),
  localparam int HALF = PERIOD / 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  output logic [PH_W-1:0] phase,
  output logic            wave_on
);
  localparam logic [PH_W-1:0] LAST   = PH_W'(PERIOD - 1);
  localparam logic [PH_W-1:0] HALF_L = PH_W'(HALF - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= '0;
      wave_on <= 1'b1;
    end else if (tick) begin
      if (phase == LAST) begin
        phase   <= '0;
        wave_on <= 1'b1;
      end else begin
        phase <= phase + 1'b1;
        if (phase == HALF_L) wave_on <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/attr_duty_gen.sv
module attr_duty_gen
  import attr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [CODE_W-1:0] bright_code,
  output logic [SLOT_W-1:0] slot,
  output logic              lit
);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOTS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)                  slot <= '0;
    else if (tick) begin
      if (slot == SLOT_LAST)     slot <= '0;
      else                       slot <= slot + 1'b1;
    end
  end

  // Lit slots lead the sub-period.
  assign lit = (slot < duty_of(bright_code));
endmodule

// File: rtl/attr_mask_sel.sv
module attr_mask_sel #(
  parameter int DIGITS = 8,
  localparam int IDX_W = $clog2(DIGITS)
) (
  input  logic              flash_en,
  input  logic              blink_en,
  input  logic [DIGITS-1:0] flash_mask,
  input  logic [IDX_W-1:0]  digit_idx,
  output logic              gated
);
  logic [DIGITS-1:0] gate_vec;

  for (genvar d = 0; d < DIGITS; d++) begin : g_dig
    // Blink covers every digit; flash only marked ones.
    assign gate_vec[d] = blink_en | (flash_en & flash_mask[d]);
  end

  assign gated = gate_vec[digit_idx];
endmodule

// File: rtl/attr_gate.sv
module attr_gate
  import attr_pkg::*;
#(
  parameter int PERIOD = 28672,
  parameter int DIGITS = 8,
  localparam int IDX_W = $clog2(DIGITS),
  localparam int PH_W  = $clog2(PERIOD)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [CODE_W-1:0] bright_code,
  input  logic              flash_en,
  input  logic              blink_en,
  input  logic [DIGITS-1:0] flash_mask,
  input  logic [IDX_W-1:0]  digit_idx,
  output logic              col_en
);
  logic [PH_W-1:0]   phase;
  logic              wave_on;
  logic [SLOT_W-1:0] slot;
  logic              lit;
  logic              gated;

  attr_prescaler #(.PERIOD(PERIOD)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .phase(phase), .wave_on(wave_on)
  );

  attr_duty_gen u_duty (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .bright_code(bright_code), .slot(slot), .lit(lit)
  );

  attr_mask_sel #(.DIGITS(DIGITS)) u_sel (
    .flash_en(flash_en), .blink_en(blink_en),
    .flash_mask(flash_mask), .digit_idx(digit_idx), .gated(gated)
  );

  assign col_en = lit & (wave_on | ~gated);
endmodule

// File: rtl/attr_gate_chk.sv
module attr_gate_chk
  import attr_pkg::*;
#(
  parameter int PH_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic [CODE_W-1:0] bright_code,
  input logic              flash_en,
  input logic              blink_en,
  input logic [SLOT_W-1:0] slot,
  input logic [PH_W-1:0]   phase,
  input logic              wave_on,
  input logic              col_en
);
  // R3
  blank_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bright_code == 3'd7) |-> !col_en);

  // R7
  blink_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blink_en && !wave_on) |-> !col_en);

  // R6
  plain_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!blink_en && !flash_en && bright_code == 3'd0) |-> col_en);

  // R8
  hold_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(slot) && $stable(phase)));

  // R2
  slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot < SLOT_W'(SLOTS));
endmodule

bind attr_gate attr_gate_chk #(.PH_W(PH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .bright_code(bright_code),
  .flash_en(flash_en), .blink_en(blink_en), .slot(slot), .phase(phase),
  .wave_on(wave_on), .col_en(col_en)
);

// File: tb/attr_gate_tb.sv
module attr_gate_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PERIOD = 28672;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [2:0] bright_code = 3'd0;
  logic       flash_en = 1'b0;
  logic       blink_en = 1'b0;
  logic [7:0] flash_mask = 8'h00;
  logic [2:0] digit_idx = 3'd0;
  logic       col_en;

  int checks = 0;
  int errors = 0;
  int n = 0;          // ticks since reset
  bit model_ok = 0;
  bit last_tick = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  attr_gate u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bright_code(bright_code),
    .flash_en(flash_en), .blink_en(blink_en), .flash_mask(flash_mask),
    .digit_idx(digit_idx), .col_en(col_en)
  );

  function automatic int duty(input logic [2:0] c);
    int t[8] = '{15, 12, 8, 6, 4, 3, 2, 0};
    return t[c];
  endfunction

  always @(posedge clk) begin
    last_tick <= tick;
    if (!rst_n) begin n <= 0; model_ok <= 1; end
    else if (tick) n <= n + 1;
  end

  always @(negedge clk) begin
    if (rst_n && model_ok) begin
      bit lit, wave, gate, exp;
      string tag;
      lit  = (n % 15) < duty(bright_code);
      wave = (n % PERIOD) < PERIOD / 2;
      gate = blink_en || (flash_en && flash_mask[digit_idx]);
      exp  = lit && (wave || !gate);
      if (bright_code == 3'd7)                    tag = "R3";
      else if (!last_tick)                        tag = "R8";
      else if (!wave && blink_en)                 tag = "R7";
      else if (!wave && flash_en)                 tag = "R5";
      else if (!flash_en && flash_mask[digit_idx]) tag = "R6";
      else if (!wave)                             tag = "R4";
      else                                        tag = "R2 R9";
      checks++;
      if (col_en !== exp) begin
        errors++;
        $display("FAIL %s tick=%0d code=%0d col_en=%b expected %b",
                 tag, n, bright_code, col_en, exp);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired col_en=%b expected finish", col_en);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: first cycle after reset is slot 0, on half, full brightness
    checks++;
    if (col_en !== 1'b1) begin
      errors++;
      $display("FAIL R1 reset state col_en=%b expected 1", col_en);
    end
    flash_mask = 8'h5A;
    for (int i = 0; i < 66000; i++) begin
      @(posedge clk);
      #1;
      tick        = ((i % 211) < 200) && !(i >= 20000 && i < 20400);
      bright_code = 3'((i / 61) % 8);
      digit_idx   = 3'(i % 8);
      flash_en    = ((i / 5000) % 2) == 1;
      blink_en    = ((i / 7000) % 3) == 2;
      if (i % 9000 == 8999) flash_mask = ~flash_mask;
      rst_n       = !(i >= 40000 && i < 40003);
    end
    @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule